// File: doc/BRIEF.md
# Output Voltage Window Monitor

This block watches a digitized output-voltage sample and reports whether it sits inside a window built around the programmed reference code. It produces an over-voltage flag, an under-voltage flag and a power-good indication. Each flag has hysteresis: it asserts at one threshold and releases at a different one, so a sample dithering near a limit does not make the flag chatter.

All four thresholds are fixed percentages of the reference code, computed with integer multiply and truncating divide. They are registered and recomputed only when the reference code changes. The flags move only on cycles where the sample strobe is high. Power-good combines the voltage window with a soft-start-complete input. Latching of faults and any action on the power stage are left to the sequencer that reads these flags.

Top module: `vout_window_mon`

## Requirements
- R1: During and right after reset, uv is 1, ov is 0 and pgood is 0.
- R2: On a strobe, ov goes to 1 when sample is strictly greater than floor(ref_code*115/100); a sample equal to that value leaves ov at 0.
- R3: Once ov is 1, it goes to 0 only on a strobe whose sample is strictly less than floor(ref_code*113/100); samples at or above that value hold ov at 1.
- R4: On a strobe, uv goes to 1 when sample is strictly less than floor(ref_code*90/100); a sample equal to that value leaves uv at 0.
- R5: Once uv is 1, it goes to 0 only on a strobe whose sample is strictly greater than floor(ref_code*92/100); samples at or below that value hold uv at 1.
- R6: ov and uv change only at a rising clock edge where sample_vld is 1; the new values appear right after that edge. Sample changes without the strobe have no effect.
- R7: pgood equals ss_done AND NOT ov AND NOT uv, and follows ss_done without waiting for a strobe.
- R8: After ref_code changes and is then held, strobes issued from the second rising edge onward use thresholds derived from the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_code | input | W | Programmed reference value |
| sample | input | W | Digitized output-voltage sample |
| sample_vld | input | 1 | Sample strobe; flags update on edges where it is 1 |
| ss_done | input | 1 | Soft-start has completed |
| ov | output | 1 | Over-voltage flag |
| uv | output | 1 | Under-voltage flag |
| pgood | output | 1 | Power-good indication |

## Verification
The assertions take for granted that ref_code is held steady for at least two cycles before a strobe that should use it, since the thresholds they compare against lag the code by one register. They also assume the strobe inputs are free of X once reset is released. The stimulus changes ref_code only between strobes and then idles three cycles, and drives sample, sample_vld and ss_done on falling edges so every strobe is a clean single-cycle pulse.

// File: rtl/vout_window_mon.sv
module vout_window_mon #(
  parameter int W          = 12,
  parameter int PCT_W      = 8,
  parameter int OV_SET_PCT = 115,
  parameter int OV_CLR_PCT = 113,
  parameter int UV_SET_PCT = 90,
  parameter int UV_CLR_PCT = 92
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ref_code,
  input  logic [W-1:0] sample,
  input  logic         sample_vld,
  input  logic         ss_done,
  output logic         ov,
  output logic         uv,
  output logic         pgood
);

  localparam int PW = W + PCT_W;
  localparam int TW = W + 1;

  function automatic logic [TW-1:0] scale(input logic [W-1:0] r, input int pct);
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;
    prod = PW'(r) * PW'(pct);
    quo  = prod / PW'(100);
    return quo[TW-1:0];
  endfunction

  logic [W-1:0]  ref_q;
  logic [TW-1:0] ov_set, ov_clr, uv_set, uv_clr;
  logic [TW-1:0] smp;
  logic          ov_nx, uv_nx;

  assign smp = {1'b0, sample};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      ov_set <= '0;
      ov_clr <= '0;
      uv_set <= '0;
      uv_clr <= '0;
    end else if (ref_code != ref_q) begin
      ref_q  <= ref_code;
      ov_set <= scale(ref_code, OV_SET_PCT);
      ov_clr <= scale(ref_code, OV_CLR_PCT);
      uv_set <= scale(ref_code, UV_SET_PCT);
      uv_clr <= scale(ref_code, UV_CLR_PCT);
    end
  end

  always_comb begin
    ov_nx = ov;
    uv_nx = uv;
    if (!ov && smp > ov_set) ov_nx = 1'b1;
    if (ov && smp < ov_clr)  ov_nx = 1'b0;
    if (!uv && smp < uv_set) uv_nx = 1'b1;
    if (uv && smp > uv_clr)  uv_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov <= 1'b0;
      uv <= 1'b1;
    end else if (sample_vld) begin
      ov <= ov_nx;
      uv <= uv_nx;
    end
  end

  assign pgood = ss_done & ~ov & ~uv;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (uv && !ov && !pgood));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sample_vld) && $past(rst_n)) |-> ($stable(ov) && $stable(uv)));

  assert_ov_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov) |-> ($past(sample_vld) && ($past(smp) > $past(ov_set))));

  assert_ov_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ov) && $past(rst_n)) |-> ($past(sample_vld) && ($past(smp) < $past(ov_clr))));

  assert_uv_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(uv) && $past(rst_n)) |-> ($past(sample_vld) && ($past(smp) < $past(uv_set))));

  assert_uv_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv) |-> ($past(sample_vld) && ($past(smp) > $past(uv_clr))));

endmodule

// File: tb/vout_window_mon_tb.sv
module vout_window_mon_tb;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ref_code = '0;
  logic [W-1:0] sample = '0;
  logic         sample_vld = 1'b0;
  logic         ss_done = 1'b0;
  logic         ov, uv, pgood;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic ov; logic uv; logic pg; string tag; } exp_t;
  exp_t q[$];

  bit m_ov, m_uv;
  int r_ref;

  vout_window_mon #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code), .sample(sample),
    .sample_vld(sample_vld), .ss_done(ss_done), .ov(ov), .uv(uv), .pgood(pgood)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ov/uv/pg actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobe(input int s, input bit ss, input string tag);
    exp_t e;
    int ovs, ovc, uvs, uvc;
    @(negedge clk);
    sample = W'(s);
    ss_done = ss;
    sample_vld = 1'b1;
    ovs = r_ref * 115 / 100;
    ovc = r_ref * 113 / 100;
    uvs = r_ref * 90 / 100;
    uvc = r_ref * 92 / 100;
    if (!m_ov) begin if (s > ovs) m_ov = 1; end
    else if (s < ovc) m_ov = 0;
    if (!m_uv) begin if (s < uvs) m_uv = 1; end
    else if (s > uvc) m_uv = 0;
    e.ov = m_ov; e.uv = m_uv; e.pg = ss & !m_ov & !m_uv; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic set_ref(input int r);
    @(negedge clk);
    ref_code = W'(r);
    r_ref = r;
    repeat (3) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, {ov, uv, pgood}, {e.ov, e.uv, e.pg});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    m_ov = 0; m_uv = 1; r_ref = 1000;
    ref_code = 12'd1000;
    repeat (3) @(negedge clk);
    check("R1 reset held", {ov, uv, pgood}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ov, uv, pgood}, 3'b010);
    repeat (2) @(negedge clk);

    strobe(1000, 0, "R5 uv release, R7 pgood gated by ss_done");
    strobe(1000, 1, "R7 pgood in window");
    strobe(1150, 1, "R2 equal to ov set no trip");
    strobe(1151, 1, "R2 ov trip");
    strobe(1140, 1, "R3 ov hold between");
    strobe(1130, 1, "R3 equal to ov clear holds");
    strobe(1129, 1, "R3 ov clears");
    strobe(900, 1, "R4 equal to uv set no trip");
    strobe(899, 1, "R4 uv trip");
    strobe(920, 1, "R5 equal to uv clear holds");
    strobe(921, 1, "R5 uv clears");
    repeat (2) @(negedge clk);

    sample = 12'd100;
    repeat (3) @(negedge clk);
    check("R6 no strobe low sample ignored", {ov, uv, pgood}, 3'b001);
    sample = 12'd3000;
    repeat (3) @(negedge clk);
    check("R6 no strobe high sample ignored", {ov, uv, pgood}, 3'b001);

    ss_done = 1'b0;
    #1 check("R7 pgood follows ss_done low", {ov, uv, pgood}, 3'b000);
    ss_done = 1'b1;
    #1 check("R7 pgood follows ss_done high", {ov, uv, pgood}, 3'b001);

    set_ref(2000);
    strobe(1000, 1, "R8 new ref uv trip");
    strobe(1840, 1, "R8 new uv clear equal holds");
    strobe(1841, 1, "R8 new uv clear");
    strobe(2300, 1, "R8 new ov set equal no trip");
    strobe(2301, 1, "R8 new ov trip");
    strobe(2259, 1, "R8 new ov clear");

    set_ref(3333);
    strobe(3832, 1, "R2 truncated ov set equal");
    strobe(3833, 1, "R2 truncated ov trip");
    strobe(2000, 1, "R3 R4 ov clear and uv trip same strobe");
    strobe(3066, 1, "R5 truncated uv clear equal holds");
    strobe(3067, 1, "R5 truncated uv clear");

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule